// File: doc/BRIEF.md
# Device Enable Field Controller

This block turns enable and disable requests for individual devices into updates of packed control fields held in a small set of configuration registers. A request carries a device number and the wanted state. The block finds the ID range that holds that device. It works out where the device's field sits in the range's register, and rewrites only that field with the range's enable or disable code.

After the write, the block may have to wait on a status field. If a status range covers the device, the block watches that field in the incoming status registers. The status field has its own register, bit position, width and codes. The operation completes only when the field shows the code for the requested state.

Requests that cannot be carried out still finish with a one-cycle done pulse, with an error flag raised in that cycle. Such a request names a device with no control range, or asks to disable a field that may only ever be enabled. The layout of the ranges is set entirely through parameters, with at most eight control ranges and eight status ranges.

Top module: `devfield_ctrl`

## Requirements
- R1: During and right after reset, `ctl_regs` equals `CTL_RESET` (all zero by default) and `busy`, `done` and `err` are low.
- R2: An accepted enable request writes the range's enable code into bits `lsb + width*(id - first)` upward of the range's register. Default control map, with register 0 at bits 31:0 of `ctl_regs` and register 1 at bits 63:32:
  - ids 0-7: register 0, bit id, width 1, enable 1, disable 0.
  - ids 8-11: register 0, from bit 8, width 2, enable 3, disable 0.
  - ids 12-15: register 0, from bit 16, width 1, enable 1, enable-only.
  - ids 16-19: register 1, from bit 4, width 3, enable 5, disable 2.
  - ids 20-27: register 1, from bit 16, width 1, enable 1, disable 0.
- R3: A write changes only the addressed device's field; every other bit of every control register keeps its value.
- R4: An accepted disable request for a range that is not enable-only writes that range's disable code into the device's field.
- R5: A disable request for an enable-only range writes nothing and finishes with `done` and `err` high together; once such a field holds its enable code it keeps it.
- R6: A request whose id has no control range (ids 28 to 31 by default, or any id of `NUM_IDS` or above) writes nothing and finishes with `done` and `err` high together.
- R7: When a status range covers the id, `done` rises only in the cycle after the status field equals the range's code for the requested state. If the field already matches at the first compare, that is two cycles after the write. Default status map, with status register 0 at bits 31:0 of `stat_regs` and register 1 at bits 63:32:
  - ids 8-11: status register 0, bit id-8, width 1, enabled 1, disabled 0.
  - ids 16-19: status register 0, from bit 8, width 2, enabled 2, disabled 1.
  - ids 12-15: status register 1, bit id-12, width 1, enabled 1, disabled 0.
- R8: A request whose id has no status range shows its updated `ctl_regs` and `done` in the second cycle after the clock edge that accepted it. A request refused under R5 or R6 raises `done` in that same cycle.
- R9: `busy` rises in the cycle after a request is accepted and stays high up to and including the `done` cycle. A request presented while `busy` is high is ignored and causes no write and no extra `done`.
- R10: `done` lasts exactly one cycle per accepted request, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_id | input | ID_W | Device number of the request |
| req_on | input | 1 | 1 asks for enable, 0 for disable |
| stat_regs | input | STAT_REGS*REG_W | Status registers, register k at bits k*REG_W upward |
| ctl_regs | output | CTL_REGS*REG_W | Control registers, register k at bits k*REG_W upward |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with `done` |

## Verification
Requests go to ranges of one, two and three bits per field, at the first and last ids of ranges, and to both control registers, so that a wrong position formula or a wrong register select shows in the full register compare. Status-waiting requests are held for several cycles before the correct code is driven. In one case the status field first shows the opposite state's code, which separates the status encoding from the control encoding. A disable whose status already matches shows that completion does not add needless delay. A disable of an enable-only field, ids with no control range and ids past the id space must finish with the error flag and leave the registers untouched. A second request injected while the block waits must leave no trace.

// File: rtl/devfield_pkg.sv
package devfield_pkg;

   typedef struct packed {
      logic       used;
      logic [7:0] first_id;
      logic [7:0] count;
      logic [3:0] reg_sel;
      logic [7:0] on_code;
      logic [7:0] off_code;
      logic       lock_on;
      logic [7:0] lsb;
      logic [3:0] width;
   } ctl_span_t;

   typedef struct packed {
      logic       used;
      logic [7:0] first_id;
      logic [7:0] count;
      logic [3:0] reg_sel;
      logic [7:0] on_code;
      logic [7:0] off_code;
      logic [7:0] lsb;
      logic [3:0] width;
   } stat_span_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_APPLY,
      ST_HOLD,
      ST_REPORT
   } seq_state_t;

   localparam ctl_span_t  CTL_NONE  = '0;
   localparam stat_span_t STAT_NONE = '0;

   function automatic ctl_span_t mk_ctl(int first, int count, int rsel, int on, int off,
                                        bit lock, int lsb, int width);
      ctl_span_t s;
      s.used     = 1'b1;
      s.first_id = 8'(first);
      s.count    = 8'(count);
      s.reg_sel  = 4'(rsel);
      s.on_code  = 8'(on);
      s.off_code = 8'(off);
      s.lock_on  = lock;
      s.lsb      = 8'(lsb);
      s.width    = 4'(width);
      return s;
   endfunction

   function automatic stat_span_t mk_stat(int first, int count, int rsel, int on, int off,
                                          int lsb, int width);
      stat_span_t s;
      s.used     = 1'b1;
      s.first_id = 8'(first);
      s.count    = 8'(count);
      s.reg_sel  = 4'(rsel);
      s.on_code  = 8'(on);
      s.off_code = 8'(off);
      s.lsb      = 8'(lsb);
      s.width    = 4'(width);
      return s;
   endfunction

   // Index 0 is the rightmost entry of each concatenation.
   localparam ctl_span_t [7:0] DEF_CTL_MAP = {
      CTL_NONE, CTL_NONE, CTL_NONE,
      mk_ctl(20, 8, 1, 1, 0, 1'b0, 16, 1),
      mk_ctl(16, 4, 1, 5, 2, 1'b0,  4, 3),
      mk_ctl(12, 4, 0, 1, 0, 1'b1, 16, 1),
      mk_ctl( 8, 4, 0, 3, 0, 1'b0,  8, 2),
      mk_ctl( 0, 8, 0, 1, 0, 1'b0,  0, 1)
   };

   localparam stat_span_t [7:0] DEF_STAT_MAP = {
      STAT_NONE, STAT_NONE, STAT_NONE, STAT_NONE, STAT_NONE,
      mk_stat(12, 4, 1, 1, 0, 0, 1),
      mk_stat(16, 4, 0, 2, 1, 8, 2),
      mk_stat( 8, 4, 0, 1, 0, 0, 1)
   };

endpackage

// File: rtl/devfield_lookup.sv
module devfield_lookup
   import devfield_pkg::*;
#(
   parameter int NUM_IDS    = 32,
   parameter int ID_W       = 6,
   parameter int REG_W      = 32,
   parameter int CTL_SPANS  = 8,
   parameter int STAT_SPANS = 8,
   parameter ctl_span_t  [CTL_SPANS-1:0]  CTL_MAP  = DEF_CTL_MAP,
   parameter stat_span_t [STAT_SPANS-1:0] STAT_MAP = DEF_STAT_MAP
) (
   input  logic [ID_W-1:0]  id,
   input  logic             on,
   output logic             ctl_hit,
   output logic             ctl_lock,
   output logic [3:0]       ctl_sel,
   output logic [REG_W-1:0] ctl_mask,
   output logic [REG_W-1:0] ctl_val,
   output logic             stat_hit,
   output logic [3:0]       stat_sel,
   output logic [REG_W-1:0] stat_mask,
   output logic [REG_W-1:0] stat_want
);

   localparam int XW = (ID_W > 8 ? ID_W : 8) + 1;

   logic [XW-1:0] id_x;
   logic          id_ok;

   assign id_x  = XW'(id);
   assign id_ok = (id_x < XW'(NUM_IDS));

   logic [CTL_SPANS-1:0] c_hit;
   logic [REG_W-1:0]     c_mask [CTL_SPANS];
   logic [REG_W-1:0]     c_val  [CTL_SPANS];

   logic [STAT_SPANS-1:0] s_hit;
   logic [REG_W-1:0]      s_mask [STAT_SPANS];
   logic [REG_W-1:0]      s_val  [STAT_SPANS];

   for (genvar g = 0; g < CTL_SPANS; g++) begin : g_ctl
      localparam ctl_span_t S = CTL_MAP[g];
      localparam logic [REG_W-1:0] FM = REG_W'((64'd1 << S.width) - 64'd1);
      logic [XW-1:0] rel;
      logic [15:0]   pos;
      logic [7:0]    code;
      assign rel  = id_x - XW'(S.first_id);
      assign pos  = 16'(S.lsb) + 16'(S.width) * 16'(rel);
      assign code = on ? S.on_code : S.off_code;
      assign c_hit[g]  = S.used && id_ok && (id_x >= XW'(S.first_id)) &&
                         (id_x < XW'(S.first_id) + XW'(S.count));
      assign c_mask[g] = FM << pos;
      assign c_val[g]  = (REG_W'(code) & FM) << pos;
   end

   for (genvar g = 0; g < STAT_SPANS; g++) begin : g_stat
      localparam stat_span_t S = STAT_MAP[g];
      localparam logic [REG_W-1:0] FM = REG_W'((64'd1 << S.width) - 64'd1);
      logic [XW-1:0] rel;
      logic [15:0]   pos;
      logic [7:0]    code;
      assign rel  = id_x - XW'(S.first_id);
      assign pos  = 16'(S.lsb) + 16'(S.width) * 16'(rel);
      assign code = on ? S.on_code : S.off_code;
      assign s_hit[g]  = S.used && id_ok && (id_x >= XW'(S.first_id)) &&
                         (id_x < XW'(S.first_id) + XW'(S.count));
      assign s_mask[g] = FM << pos;
      assign s_val[g]  = (REG_W'(code) & FM) << pos;
   end

   // Lowest-numbered matching range wins.
   always_comb begin
      ctl_hit  = 1'b0;
      ctl_lock = 1'b0;
      ctl_sel  = '0;
      ctl_mask = '0;
      ctl_val  = '0;
      for (int i = CTL_SPANS - 1; i >= 0; i--) begin
         if (c_hit[i]) begin
            ctl_hit  = 1'b1;
            ctl_lock = CTL_MAP[i].lock_on;
            ctl_sel  = CTL_MAP[i].reg_sel;
            ctl_mask = c_mask[i];
            ctl_val  = c_val[i];
         end
      end
   end

   always_comb begin
      stat_hit  = 1'b0;
      stat_sel  = '0;
      stat_mask = '0;
      stat_want = '0;
      for (int i = STAT_SPANS - 1; i >= 0; i--) begin
         if (s_hit[i]) begin
            stat_hit  = 1'b1;
            stat_sel  = STAT_MAP[i].reg_sel;
            stat_mask = s_mask[i];
            stat_want = s_val[i];
         end
      end
   end

endmodule

// File: rtl/devfield_bank.sv
module devfield_bank #(
   parameter int REG_W    = 32,
   parameter int CTL_REGS = 2,
   parameter logic [CTL_REGS*REG_W-1:0] CTL_RESET = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [3:0]                wr_sel,
   input  logic [REG_W-1:0]          wr_mask,
   input  logic [REG_W-1:0]          wr_val,
   output logic [CTL_REGS*REG_W-1:0] regs
);

   for (genvar k = 0; k < CTL_REGS; k++) begin : g_reg
      logic [REG_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= CTL_RESET[k*REG_W +: REG_W];
         end else if (wr_en && (wr_sel == 4'(k))) begin
            r <= (r & ~wr_mask) | (wr_val & wr_mask);
         end
      end
      assign regs[k*REG_W +: REG_W] = r;
   end

endmodule

// File: rtl/devfield_seq.sv
module devfield_seq
   import devfield_pkg::*;
#(
   parameter int ID_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   input  logic            req_on,
   input  logic            ctl_hit,
   input  logic            ctl_lock,
   input  logic            stat_hit,
   input  logic            stat_ok,
   output logic [ID_W-1:0] cur_id,
   output logic            cur_on,
   output logic            wr_en,
   output logic            busy,
   output logic            done,
   output logic            err
);

   seq_state_t state;
   logic       bad;
   logic       refuse;

   assign refuse = !ctl_hit || (!cur_on && ctl_lock);
   assign wr_en  = (state == ST_APPLY) && !refuse;
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_REPORT);
   assign err    = done && bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur_id <= '0;
         cur_on <= 1'b0;
         bad    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_id <= req_id;
                  cur_on <= req_on;
                  bad    <= 1'b0;
                  state  <= ST_APPLY;
               end
            end
            ST_APPLY: begin
               if (refuse) begin
                  bad   <= 1'b1;
                  state <= ST_REPORT;
               end else begin
                  state <= stat_hit ? ST_HOLD : ST_REPORT;
               end
            end
            ST_HOLD: begin
               if (stat_ok) state <= ST_REPORT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/devfield_ctrl.sv
module devfield_ctrl
   import devfield_pkg::*;
#(
   parameter int NUM_IDS    = 32,
   parameter int ID_W       = 6,
   parameter int REG_W      = 32,
   parameter int CTL_REGS   = 2,
   parameter int STAT_REGS  = 2,
   parameter int CTL_SPANS  = 8,
   parameter int STAT_SPANS = 8,
   parameter ctl_span_t  [CTL_SPANS-1:0]  CTL_MAP  = DEF_CTL_MAP,
   parameter stat_span_t [STAT_SPANS-1:0] STAT_MAP = DEF_STAT_MAP,
   parameter logic [CTL_REGS*REG_W-1:0]   CTL_RESET = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ID_W-1:0]            req_id,
   input  logic                       req_on,
   input  logic [STAT_REGS*REG_W-1:0] stat_regs,
   output logic [CTL_REGS*REG_W-1:0]  ctl_regs,
   output logic                       busy,
   output logic                       done,
   output logic                       err
);

   if (REG_W < 1 || REG_W > 64) begin : g_bad_w
      $error("REG_W must lie in 1..64");
   end
   if (NUM_IDS > (2 ** ID_W)) begin : g_bad_ids
      $error("NUM_IDS exceeds the id space of ID_W bits");
   end
   if (CTL_REGS < 1 || CTL_REGS > 16 || STAT_REGS < 1 || STAT_REGS > 16) begin : g_bad_regs
      $error("register counts must lie in 1..16");
   end
   for (genvar g = 0; g < CTL_SPANS; g++) begin : g_chk_ctl
      if (CTL_MAP[g].used && ((int'(CTL_MAP[g].lsb) + int'(CTL_MAP[g].width) *
          int'(CTL_MAP[g].count) > REG_W) || int'(CTL_MAP[g].reg_sel) >= CTL_REGS ||
          CTL_MAP[g].width == 0 || CTL_MAP[g].width > 8)) begin : g_bad
         $error("control range does not fit its register");
      end
   end
   for (genvar g = 0; g < STAT_SPANS; g++) begin : g_chk_stat
      if (STAT_MAP[g].used && ((int'(STAT_MAP[g].lsb) + int'(STAT_MAP[g].width) *
          int'(STAT_MAP[g].count) > REG_W) || int'(STAT_MAP[g].reg_sel) >= STAT_REGS ||
          STAT_MAP[g].width == 0 || STAT_MAP[g].width > 8)) begin : g_bad
         $error("status range does not fit its register");
      end
   end

   logic [ID_W-1:0]  cur_id;
   logic             cur_on;
   logic             ctl_hit, ctl_lock, stat_hit, stat_ok, wr_en;
   logic [3:0]       ctl_sel, stat_sel;
   logic [REG_W-1:0] ctl_mask, ctl_val, stat_mask, stat_want, stat_word;

   devfield_lookup #(
      .NUM_IDS(NUM_IDS), .ID_W(ID_W), .REG_W(REG_W),
      .CTL_SPANS(CTL_SPANS), .STAT_SPANS(STAT_SPANS),
      .CTL_MAP(CTL_MAP), .STAT_MAP(STAT_MAP)
   ) i_lookup (
      .id(cur_id), .on(cur_on),
      .ctl_hit(ctl_hit), .ctl_lock(ctl_lock), .ctl_sel(ctl_sel),
      .ctl_mask(ctl_mask), .ctl_val(ctl_val),
      .stat_hit(stat_hit), .stat_sel(stat_sel),
      .stat_mask(stat_mask), .stat_want(stat_want)
   );

   always_comb begin
      stat_word = '0;
      for (int k = 0; k < STAT_REGS; k++) begin
         if (stat_sel == 4'(k)) stat_word = stat_regs[k*REG_W +: REG_W];
      end
   end

   assign stat_ok = ((stat_word & stat_mask) == stat_want);

   devfield_seq #(.ID_W(ID_W)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_id(req_id), .req_on(req_on),
      .ctl_hit(ctl_hit), .ctl_lock(ctl_lock),
      .stat_hit(stat_hit), .stat_ok(stat_ok),
      .cur_id(cur_id), .cur_on(cur_on), .wr_en(wr_en),
      .busy(busy), .done(done), .err(err)
   );

   devfield_bank #(
      .REG_W(REG_W), .CTL_REGS(CTL_REGS), .CTL_RESET(CTL_RESET)
   ) i_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(ctl_sel), .wr_mask(ctl_mask), .wr_val(ctl_val),
      .regs(ctl_regs)
   );

endmodule

// File: rtl/devfield_chk.sv
module devfield_chk
   import devfield_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int CTL_REGS  = 2,
   parameter int CTL_SPANS = 8,
   parameter ctl_span_t [CTL_SPANS-1:0] CTL_MAP = DEF_CTL_MAP
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic                      busy,
   input logic                      done,
   input logic                      err,
   input logic [CTL_REGS*REG_W-1:0] ctl_regs
);

   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(ctl_regs));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   for (genvar g = 0; g < CTL_SPANS; g++) begin : g_lock
      localparam ctl_span_t S = CTL_MAP[g];
      if (S.used && S.lock_on && int'(S.reg_sel) < CTL_REGS) begin : g_on
         for (genvar i = 0; i < int'(S.count); i++) begin : g_fld
            localparam int P = int'(S.lsb) + int'(S.width) * i;
            localparam logic [REG_W-1:0] M = REG_W'((64'd1 << S.width) - 64'd1) << P;
            localparam logic [REG_W-1:0] V = (REG_W'(S.on_code) & REG_W'((64'd1 << S.width) - 64'd1)) << P;
            assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
               ((ctl_regs[int'(S.reg_sel)*REG_W +: REG_W] & M) == V) |=>
               ((ctl_regs[int'(S.reg_sel)*REG_W +: REG_W] & M) == V));
         end
      end
   end

endmodule

bind devfield_ctrl devfield_chk #(
   .REG_W(REG_W), .CTL_REGS(CTL_REGS), .CTL_SPANS(CTL_SPANS), .CTL_MAP(CTL_MAP)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
   .busy(busy), .done(done), .err(err), .ctl_regs(ctl_regs)
);

// File: tb/test_devfield_ctrl.sv
module test_devfield_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_id = '0;
   logic        req_on = 1'b0;
   logic [63:0] stat_drv = '0;
   logic [63:0] ctl_regs;
   logic        busy, done, err;

   always #4 clk = ~clk;

   devfield_ctrl i_devfield_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_on(req_on), .stat_regs(stat_drv), .ctl_regs(ctl_regs),
      .busy(busy), .done(done), .err(err)
   );

   typedef struct {
      logic [63:0] regs;
      logic        bad;
      string       tag;
   } item_t;

   item_t       sb[$];
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          running = 1'b0;
   logic [63:0] exp_ctl = '0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void ctl_info(input int id, output bit has, output int rsel,
                                    output int lsb, output int w, output int on,
                                    output int off, output bit lock);
      has = 1; lock = 0; rsel = 0; w = 1; on = 1; off = 0; lsb = 0;
      if (id < 8) lsb = id;
      else if (id < 12) begin lsb = 8 + 2 * (id - 8); w = 2; on = 3; end
      else if (id < 16) begin lsb = 16 + id - 12; lock = 1; end
      else if (id < 20) begin rsel = 1; lsb = 4 + 3 * (id - 16); w = 3; on = 5; off = 2; end
      else if (id < 28) begin rsel = 1; lsb = 16 + id - 20; end
      else has = 0;
   endfunction

   function automatic void stat_info(input int id, output bit has, output int rsel,
                                     output int lsb, output int w, output int on,
                                     output int off);
      has = 1; rsel = 0; w = 1; on = 1; off = 0; lsb = 0;
      if (id >= 8 && id < 12) lsb = id - 8;
      else if (id >= 12 && id < 16) begin rsel = 1; lsb = id - 12; end
      else if (id >= 16 && id < 20) begin lsb = 8 + 2 * (id - 16); w = 2; on = 2; off = 1; end
      else has = 0;
   endfunction

   function automatic logic [63:0] put_field(logic [63:0] v, int rsel, int lsb, int w, int code);
      for (int b = 0; b < w; b++) v[rsel*32 + lsb + b] = 1'((code >> b) & 1);
      return v;
   endfunction

   function automatic int get_field(logic [63:0] v, int rsel, int lsb, int w);
      int r = 0;
      for (int b = 0; b < w; b++) r |= int'(v[rsel*32 + lsb + b]) << b;
      return r;
   endfunction

   // mode 0: plain; 1: status first shows the opposite code; 2: extra request while waiting
   task automatic do_req(int id, bit on, int mode, string tag);
      bit has, lock, shas, refuse, need_wait, already;
      int rsel, lsb, w, con, coff, srsel, slsb, sw, son, soff, code;
      item_t it;
      ctl_info(id, has, rsel, lsb, w, con, coff, lock);
      stat_info(id, shas, srsel, slsb, sw, son, soff);
      refuse = !has || (!on && lock);
      if (!refuse) exp_ctl = put_field(exp_ctl, rsel, lsb, w, on ? con : coff);
      it.regs = exp_ctl; it.bad = refuse; it.tag = tag;
      sb.push_back(it);
      need_wait = !refuse && shas;
      code = on ? son : soff;
      already = need_wait && (get_field(stat_drv, srsel, slsb, sw) == code);
      req_valid = 1'b1; req_id = 6'(id); req_on = on;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk({"R9 busy after accept, ", tag}, {62'd0, busy, done}, 64'd2);
      @(negedge clk);
      if (!need_wait) begin
         chk({"R8 done two cycles after accept, ", tag}, {63'd0, done}, 64'd1);
      end else if (already) begin
         chk({"R7 one status compare first, ", tag}, {63'd0, done}, 64'd0);
         @(negedge clk);
         chk({"R7 done with status already matching, ", tag}, {63'd0, done}, 64'd1);
      end else begin
         for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            chk({"R7 waiting on status, ", tag}, {62'd0, done, busy}, 64'd1);
            if (k == 0 && mode == 1) stat_drv = put_field(stat_drv, srsel, slsb, sw, on ? soff : son);
            if (k == 0 && mode == 2) begin req_valid = 1'b1; req_id = 6'd5; req_on = 1'b1; end
            if (k == 1 && mode == 2) req_valid = 1'b0;
         end
         stat_drv = put_field(stat_drv, srsel, slsb, sw, code);
         @(negedge clk);
         chk({"R7 done after status match, ", tag}, {63'd0, done}, 64'd1);
      end
      @(negedge clk);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (running) begin
         if (done) begin
            if (sb.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL R9/R10 unexpected done actual=1 expected=0");
            end else begin
               item_t it;
               it = sb.pop_front();
               chk({"R2/R3/R4 ctl_regs, ", it.tag}, ctl_regs, it.regs);
               chk({"R5/R6/R10 err, ", it.tag}, {63'd0, err}, {63'd0, it.bad});
            end
         end
         if (err && !done) begin
            n_tests++; n_fail++;
            $display("FAIL R10 err without done actual=1 expected=0");
         end
      end
   end

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ctl_regs in reset", ctl_regs, 64'd0);
      chk("R1 flags in reset", {61'd0, busy, done, err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ctl_regs after reset", ctl_regs, 64'd0);
      chk("R1 flags after reset", {61'd0, busy, done, err}, 64'd0);
      running = 1'b1;

      do_req(3,  1'b1, 0, "R2 enable id 3");
      do_req(0,  1'b1, 0, "R2 lowest id 0");
      do_req(7,  1'b1, 0, "R2 last one-bit id 7");
      do_req(9,  1'b1, 0, "R2 two-bit field id 9");
      do_req(3,  1'b0, 0, "R3/R4 disable id 3");
      do_req(17, 1'b1, 1, "R7 separate status code id 17");
      do_req(17, 1'b0, 0, "R4 disable code id 17");
      do_req(13, 1'b1, 0, "R2 enable-only id 13");
      do_req(13, 1'b0, 0, "R5 refused disable id 13");
      do_req(8,  1'b0, 0, "R7 status already matching id 8");
      do_req(30, 1'b1, 0, "R6 id 30 without range");
      do_req(40, 1'b0, 0, "R6 id 40 beyond id space");
      do_req(9,  1'b0, 2, "R9 request while busy ignored");
      do_req(27, 1'b1, 0, "R2 top id 27");
      do_req(19, 1'b1, 0, "R2 last three-bit id 19");
      do_req(16, 1'b1, 0, "R3 first three-bit id 16");

      repeat (3) @(negedge clk);
      chk("R10 every request completed once", 64'(sb.size()), 64'd0);
      chk("R9 idle at end", {63'd0, busy}, 64'd0);
      running = 1'b0;
      summary();
      $finish;
   end

endmodule